// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block keeps the two-bit operating-mode field of a converter's command register and turns that field into power controls for the converter core. One code of the field means sleep. While that code is held, the core is gated off, the ready flag is low and the output driver enable is low, so the output pin floats. The command write port and the mode read-back keep working while the block sleeps, so software can wake the converter with an ordinary register write.

When the field moves from sleep to any other code, the block powers the core and runs a two-phase wake sequence. The first phase is a fixed number of clock cycles for the internal analog and digital sections. The second phase is a programmable number of cycles that lets external circuitry such as the reference settle. The ready flag and the output enable rise only after both phases finish. If sleep is written during the sequence, the block drops straight back to sleep. A non-sleep write to an awake block leaves it awake and ready.

Top module: `lpm_sequencer`

## Requirements
- R1: When cmd_wr is high at a rising clock edge, cmd_mode is stored in the mode field at that edge. mode_rd always shows the stored field, including during sleep. With cmd_wr low, the field keeps its value.
- R2: The sleep code is binary 10. From the edge that stores 10, core_pwr_en, pwr_ready and out_en are all low, and they stay low while the field holds 10.
- R3: A synchronous active-high rst loads 10 into the mode field and drives core_pwr_en, pwr_ready and out_en low. The block therefore starts in sleep after every reset.
- R4: A write that changes the field from 10 to another code raises core_pwr_en at the capturing edge. pwr_ready rises exactly INT_CYCLES plus settle_cycles edges after the capturing edge, and not before.
- R5: With settle_cycles equal to 0, the settle phase is skipped and pwr_ready rises exactly INT_CYCLES edges after the capturing edge.
- R6: settle_cycles is sampled once, at the edge where the internal phase ends. Changes to it after that edge do not alter the current sequence.
- R7: A write of 10 during either wake phase aborts the sequence. core_pwr_en falls at the capturing edge, and pwr_ready stays low.
- R8: out_en is high only when pwr_ready is high and the stored field is not 10. It rises in the same cycle as pwr_ready.
- R9: A write of a non-sleep code while pwr_ready is high does not restart the sequence. pwr_ready and out_en stay high on every following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the mode field |
| cmd_mode | input | 2 | Mode value to store (10 = sleep) |
| settle_cycles | input | SETTLE_W | Length of the external settling phase in cycles |
| mode_rd | output | 2 | Read-back of the stored mode field |
| core_pwr_en | output | 1 | Power/clock enable for the converter core |
| pwr_ready | output | 1 | Wake sequence complete, core usable |
| out_en | output | 1 | Output driver enable (low = high impedance) |

## Verification
If the sequencer state drifts from the mode field, it shows at the ports within one clock. An output enable or ready flag left high after a sleep write is visible at the capturing edge. A sequence that does not abort keeps core_pwr_en high one cycle too long. A phase counter that is loaded wrongly or restarts moves the pwr_ready rising edge away from the exact INT_CYCLES plus settle count. The bench checks that edge on the cycle before and on the cycle it is due. A wrongly sampled settle value shifts the same edge, as does a restart on an awake write.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam logic [1:0] MODE_SLEEP = 2'b10;

  typedef enum logic [1:0] {
    PS_SLEEP  = 2'd0,
    PS_WARM   = 2'd1,
    PS_SETTLE = 2'd2,
    PS_ACTIVE = 2'd3
  } pwr_state_t;

endpackage

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_mode,
  output logic [1:0] mode_q,
  output logic [1:0] mode_nxt
);

  // value the field will hold after this edge; the FSM follows it so that
  // state and field change together
  always_comb begin
    mode_nxt = cmd_wr ? cmd_mode : mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_SLEEP;
    else     mode_q <= mode_nxt;
  end

  // R1: a write lands in the field at the capturing edge
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> (mode_q == $past(cmd_mode)));

  // R1: without a write the field holds
  a_r1_field_holds: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> $stable(mode_q));

endmodule

// File: rtl/lpm_down_counter.sv
module lpm_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             cnt_zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign cnt_zero = (cnt == '0);

  a_r4_no_load_and_dec: assert property (@(posedge clk) disable iff (rst)
    !(load && dec));

endmodule

// File: rtl/lpm_power_fsm.sv
module lpm_power_fsm
  import lpm_pkg::*;
#(
  parameter int INT_CYCLES = 16,
  parameter int SETTLE_W   = 8,
  parameter int CNT_W      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_nxt,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                cnt_zero,
  output logic                cnt_load,
  output logic [CNT_W-1:0]    cnt_load_val,
  output logic                cnt_dec,
  output logic                core_en,
  output logic                ready,
  output logic                drv_en
);

  pwr_state_t state, state_nxt;
  logic       go_sleep;

  assign go_sleep = (mode_nxt == MODE_SLEEP);

  always_comb begin
    state_nxt    = state;
    cnt_load     = 1'b0;
    cnt_load_val = '0;
    cnt_dec      = 1'b0;
    unique case (state)
      PS_SLEEP: begin
        if (!go_sleep) begin
          state_nxt    = PS_WARM;
          cnt_load     = 1'b1;
          cnt_load_val = CNT_W'(INT_CYCLES - 1);
        end
      end
      PS_WARM: begin
        if (go_sleep) begin
          state_nxt = PS_SLEEP;
        end else if (cnt_zero) begin
          if (settle_cycles == '0) begin
            state_nxt = PS_ACTIVE;
          end else begin
            state_nxt    = PS_SETTLE;
            cnt_load     = 1'b1;
            cnt_load_val = CNT_W'(settle_cycles - 1'b1);
          end
        end else begin
          cnt_dec = 1'b1;
        end
      end
      PS_SETTLE: begin
        if (go_sleep)      state_nxt = PS_SLEEP;
        else if (cnt_zero) state_nxt = PS_ACTIVE;
        else               cnt_dec   = 1'b1;
      end
      PS_ACTIVE: begin
        if (go_sleep) state_nxt = PS_SLEEP;
      end
      default: state_nxt = PS_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_SLEEP;
      core_en <= 1'b0;
      ready   <= 1'b0;
      drv_en  <= 1'b0;
    end else begin
      state   <= state_nxt;
      core_en <= (state_nxt != PS_SLEEP);
      ready   <= (state_nxt == PS_ACTIVE);
      drv_en  <= (state_nxt == PS_ACTIVE) && !go_sleep;
    end
  end

  // R7: a sleep write during either wake phase drops the core at once
  a_r7_abort_wake: assert property (@(posedge clk) disable iff (rst)
    ((state == PS_WARM || state == PS_SETTLE) && go_sleep) |=> !core_en);

  // R9: an awake block stays awake on non-sleep writes
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state == PS_ACTIVE && !go_sleep) |=> (state == PS_ACTIVE && ready));

  // R4: leaving sleep always enters the internal phase first
  a_r4_wake_order: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SLEEP && !go_sleep) |=> (state == PS_WARM));

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int INT_CYCLES = 16,
  parameter int SETTLE_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_wr,
  input  logic [1:0]          cmd_mode,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [1:0]          mode_rd,
  output logic                core_pwr_en,
  output logic                pwr_ready,
  output logic                out_en
);

  localparam int INT_W = (INT_CYCLES > 2) ? $clog2(INT_CYCLES) : 1;
  localparam int CNT_W = (INT_W > SETTLE_W) ? INT_W : SETTLE_W;

  logic [1:0]       mode_q, mode_nxt;
  logic             cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_load_val;

  lpm_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd_mode (cmd_mode),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt)
  );

  lpm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .cnt_zero (cnt_zero)
  );

  lpm_power_fsm #(
    .INT_CYCLES (INT_CYCLES),
    .SETTLE_W   (SETTLE_W),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .mode_nxt      (mode_nxt),
    .settle_cycles (settle_cycles),
    .cnt_zero      (cnt_zero),
    .cnt_load      (cnt_load),
    .cnt_load_val  (cnt_load_val),
    .cnt_dec       (cnt_dec),
    .core_en       (core_pwr_en),
    .ready         (pwr_ready),
    .drv_en        (out_en)
  );

  assign mode_rd = mode_q;

  // R2: sleep code keeps everything off
  a_r2_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SLEEP) |-> (!core_pwr_en && !pwr_ready && !out_en));

  // R8: driver enabled only when ready and awake
  a_r8_oe_gated: assert property (@(posedge clk) disable iff (rst)
    out_en |-> (pwr_ready && mode_q != MODE_SLEEP));

  // R4: ready never without core power
  a_r4_ready_powered: assert property (@(posedge clk) disable iff (rst)
    pwr_ready |-> core_pwr_en);

endmodule

// File: tb/lpm_sequencer_tb.sv
module lpm_sequencer_tb_top;

  localparam int INT_CYCLES = 8;
  localparam int SETTLE_W   = 8;
  localparam logic [1:0] SLP = 2'b10;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                cmd_wr = 1'b0;
  logic [1:0]          cmd_mode = 2'b00;
  logic [SETTLE_W-1:0] settle_cycles = '0;
  logic [1:0]          mode_rd;
  logic                core_pwr_en, pwr_ready, out_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  lpm_sequencer #(.INT_CYCLES(INT_CYCLES), .SETTLE_W(SETTLE_W)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .cmd_wr        (cmd_wr),
    .cmd_mode      (cmd_mode),
    .settle_cycles (settle_cycles),
    .mode_rd       (mode_rd),
    .core_pwr_en   (core_pwr_en),
    .pwr_ready     (pwr_ready),
    .out_en        (out_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input int core, input int rdy, input int oe);
    chk(req, "core_pwr_en", int'(core_pwr_en), core);
    chk(req, "pwr_ready", int'(pwr_ready), rdy);
    chk(req, "out_en", int'(out_en), oe);
  endtask

  // write at one edge; returns half a cycle after the capturing edge
  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk);
    cmd_wr   = 1'b1;
    cmd_mode = m;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wake_and_check(input string req, input logic [1:0] m, input int s);
    settle_cycles = SETTLE_W'(s);
    wr_mode(m);
    chk(req, "mode_rd after wake", int'(mode_rd), int'(m));
    chk_outs(req, 1, 0, 0);
    repeat (INT_CYCLES + s - 1) @(negedge clk);
    chk(req, "ready one cycle early", int'(pwr_ready), 0);
    @(negedge clk);
    chk_outs(req, 1, 1, 1);
  endtask

  task automatic t_reset_state();
    chk("R3", "mode_rd at reset", int'(mode_rd), int'(SLP));
    chk_outs("R3", 0, 0, 0);
  endtask

  task automatic t_field_rw();
    // R1: no write strobe, field unchanged
    @(negedge clk);
    cmd_mode = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1", "field without strobe", int'(mode_rd), int'(SLP));
    chk_outs("R1", 0, 0, 0);
    // R1: write during sleep accepted and read back
    wr_mode(SLP);
    chk("R1", "read in sleep", int'(mode_rd), int'(SLP));
  endtask

  task automatic t_wake_settle();
    wake_and_check("R4", 2'b00, 5);
    chk("R8", "out_en with ready", int'(out_en), 1);
  endtask

  task automatic t_awake_rewrite();
    wr_mode(2'b01);
    chk("R1", "mode_rd after awake write", int'(mode_rd), 1);
    chk_outs("R9", 1, 1, 1);
    repeat (INT_CYCLES + 3) begin
      @(negedge clk);
      chk("R9", "ready held", int'(pwr_ready), 1);
    end
  endtask

  task automatic t_sleep();
    wr_mode(SLP);
    chk("R2", "mode_rd sleep", int'(mode_rd), int'(SLP));
    chk_outs("R2", 0, 0, 0);
    repeat (4) @(negedge clk);
    chk_outs("R2", 0, 0, 0);
  endtask

  task automatic t_no_settle();
    wake_and_check("R5", 2'b11, 0);
    wr_mode(SLP);
  endtask

  task automatic t_abort();
    settle_cycles = SETTLE_W'(20);
    wr_mode(2'b00);
    repeat (INT_CYCLES + 2) @(negedge clk);
    chk("R7", "core on in settle", int'(core_pwr_en), 1);
    wr_mode(SLP);
    chk_outs("R7", 0, 0, 0);
    repeat (25) @(negedge clk);
    chk("R7", "ready after abort", int'(pwr_ready), 0);
    // abort in internal phase too
    wr_mode(2'b01);
    repeat (2) @(negedge clk);
    wr_mode(SLP);
    chk_outs("R7", 0, 0, 0);
  endtask

  task automatic t_settle_sampled();
    settle_cycles = SETTLE_W'(3);
    wr_mode(2'b00);
    repeat (INT_CYCLES + 1) @(negedge clk);
    settle_cycles = SETTLE_W'(50);
    @(negedge clk);
    chk("R6", "ready early", int'(pwr_ready), 0);
    @(negedge clk);
    chk("R6", "ready on sampled count", int'(pwr_ready), 1);
    chk("R8", "out_en on sampled count", int'(out_en), 1);
  endtask

  task automatic t_reset_awake();
    do_reset();
    chk("R3", "mode_rd after reset", int'(mode_rd), int'(SLP));
    chk_outs("R3", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_field_rw();
    t_wake_settle();
    t_awake_rewrite();
    t_sleep();
    t_no_settle();
    t_abort();
    t_settle_sampled();
    t_reset_awake();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule